// File: doc/BRIEF.md
# Constant Buffer Upload Engine

This block is the register-write front end for a set of constant buffers held in a backing memory. Software first defines a buffer by loading a base address into a high/low register pair and then issuing a definition command that carries a buffer id and a byte size. It then points an upload cursor at a buffer id and a word offset. After that, each write to any of sixteen interchangeable data registers becomes one 32-bit word write to the backing memory at base plus offset, and the cursor steps forward one word.

Every upload is checked against the size of its buffer. A write past the end is dropped and raises a sticky error flag, and the cursor stays where it was. The block also holds a binding table that maps each pair of program type and constant space to a buffer id. A lookup port reads this table. A flush strobe tells downstream caches to drop data that was changed outside the upload path. Uploads do not need a flush.

Top module: `cbu_upload_engine`

## Requirements
- R1: After reset, memWrEn, errFlag and flushPulse are 0, and every binding lookup returns bindQueryValid = 0.
- R2: A write of regData[ADDR_W-33:0] to select 0 sets the high base bits, and a write to select 1 sets the low 32 base bits. A write to select 2 defines buffer regData[22:16] with byte size regData[15:0], using the base address held at that moment.
- R3: A write to select 3 sets the upload buffer id to regData[6:0] and the upload word offset to regData[21:8].
- R4: A register write with regSel[4] = 1 (selects 16 to 31, all equivalent) produces, in the next cycle only, memWrEn = 1, memWrAddr = base + 4 × offset and memWrData = regData. The offset then advances by one word.
- R5: A size field of 0 defines a 65536-byte buffer, so word offset 16383 is accepted and offset 16384 is not.
- R6: A data write whose word offset is not below size/4, or that targets a buffer never defined, gives no memory write and sets errFlag. The offset is unchanged, so the same offset is retried after a later redefinition.
- R7: A definition whose size field has a nonzero value in bits [7:0] sets errFlag and leaves the earlier definition of that buffer in place.
- R8: A write to select 4 with regData[0] = 1 binds space regData[11:8] of program type regData[7:4] to buffer regData[18:12]. From the next cycle, a lookup of that type and space returns bindQueryValid = 1 with that id. Other pairs are not affected.
- R9: A write to select 4 with regData[0] = 0 sets errFlag and leaves the binding table unchanged.
- R10: Writing 0 to select 5 gives flushPulse = 1 for exactly the next cycle. Writing a nonzero value to select 5 gives no pulse and no error.
- R11: errFlag stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 5 | Register select |
| regData | input | 32 | Register write data |
| bindQueryProg | input | 4 | Program type for a binding lookup |
| bindQuerySpace | input | 4 | Constant space for a binding lookup |
| memWrEn | output | 1 | Backing-memory word write strobe |
| memWrAddr | output | ADDR_W | Byte address of the word write |
| memWrData | output | 32 | Word to write |
| errFlag | output | 1 | Sticky command error |
| flushPulse | output | 1 | One-cycle cache flush request |
| bindQueryId | output | 7 | Buffer id bound to the looked-up pair |
| bindQueryValid | output | 1 | Looked-up pair has a binding |

## Verification
Each register write is applied for one cycle. Its effect appears after the single register stage that follows it: the memory write, the error flag, the flush pulse and the table updates are all visible in the cycle right after the write. The bench drives each write at a falling edge and removes it at the next falling edge. It checks outputs right then, which is the one cycle in which memWrEn and flushPulse are due. Binding lookups are combinational on the stored table, so they are checked after a short settle delay once the bind write has been registered. Pulse length is checked by sampling again one falling edge later.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_BASE_HI = 5'd0;
  localparam logic [SEL_W-1:0] SEL_BASE_LO = 5'd1;
  localparam logic [SEL_W-1:0] SEL_DEFINE  = 5'd2;
  localparam logic [SEL_W-1:0] SEL_UPLOAD  = 5'd3;
  localparam logic [SEL_W-1:0] SEL_BIND    = 5'd4;
  localparam logic [SEL_W-1:0] SEL_FLUSH   = 5'd5;
  localparam int OFS_W = 14;
  localparam int PTR_W = OFS_W + 1;

  typedef struct packed {
    logic ldHi;
    logic ldLo;
    logic defOk;
    logic defBad;
    logic selUp;
    logic dataWr;
    logic bindOk;
    logic bindBad;
    logic flush;
  } cbu_strobe_t;
endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [31:0]      regData,
  output cbu_strobe_t      strobe
);
  logic sizeAligned;
  assign sizeAligned = (regData[7:0] == 8'd0);

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      strobe.dataWr  = regSel[SEL_W-1];
      strobe.ldHi    = (regSel == SEL_BASE_HI);
      strobe.ldLo    = (regSel == SEL_BASE_LO);
      strobe.defOk   = (regSel == SEL_DEFINE) && sizeAligned;
      strobe.defBad  = (regSel == SEL_DEFINE) && !sizeAligned;
      strobe.selUp   = (regSel == SEL_UPLOAD);
      strobe.bindOk  = (regSel == SEL_BIND) && regData[0];
      strobe.bindBad = (regSel == SEL_BIND) && !regData[0];
      strobe.flush   = (regSel == SEL_FLUSH) && (regData == 32'd0);
    end
  end
endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int NUM_BUF   = 128,
  parameter int NUM_SPACE = 16,
  parameter int NUM_PROG  = 16,
  parameter int ADDR_W    = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cbu_strobe_t                  strobe,
  input  logic [31:0]                  regData,
  input  logic [$clog2(NUM_PROG)-1:0]  bindQueryProg,
  input  logic [$clog2(NUM_SPACE)-1:0] bindQuerySpace,
  output logic                         memWrEn,
  output logic [ADDR_W-1:0]            memWrAddr,
  output logic [31:0]                  memWrData,
  output logic                         errFlag,
  output logic                         flushPulse,
  output logic [$clog2(NUM_BUF)-1:0]   bindQueryId,
  output logic                         bindQueryValid
);
  localparam int ID_W     = $clog2(NUM_BUF);
  localparam int HI_W     = ADDR_W - 32;
  localparam int SP_W     = $clog2(NUM_SPACE);
  localparam int PG_W     = $clog2(NUM_PROG);
  localparam int NUM_SLOT = NUM_SPACE * NUM_PROG;

  logic [HI_W-1:0]   baseHi;
  logic [31:0]       baseLo;
  logic [ADDR_W-1:0] defBase  [NUM_BUF];
  logic [PTR_W-1:0]  defWords [NUM_BUF];
  logic [ID_W:0]     slotTab  [NUM_SLOT];
  logic [ID_W-1:0]   upId;
  logic [PTR_W-1:0]  upPtr;

  // new definition: size zero stands for the full 64 KiB window
  logic [PTR_W-1:0] newWords;
  logic [ID_W-1:0]  defId;
  assign newWords = (regData[15:0] == 16'd0) ? PTR_W'(1 << OFS_W)
                                              : PTR_W'(regData[15:2]);
  assign defId = regData[16 +: ID_W];

  logic [ID_W-1:0] bindId;
  logic [SP_W-1:0] bindSpace;
  logic [PG_W-1:0] bindProg;
  assign bindId    = regData[12 +: ID_W];
  assign bindSpace = regData[8 +: SP_W];
  assign bindProg  = regData[4 +: PG_W];

  logic inRange;
  assign inRange = (upPtr < defWords[upId]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi <= '0;
      baseLo <= '0;
    end else begin
      if (strobe.ldHi) baseHi <= regData[HI_W-1:0];
      if (strobe.ldLo) baseLo <= regData;
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_def
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        defBase[b]  <= '0;
        defWords[b] <= '0;
      end else if (strobe.defOk && defId == ID_W'(b)) begin
        defBase[b]  <= {baseHi, baseLo};
        defWords[b] <= newWords;
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotTab[s] <= '0;
      else if (strobe.bindOk && {bindProg, bindSpace} == (PG_W+SP_W)'(s))
        slotTab[s] <= {1'b1, bindId};
    end
  end

  assign {bindQueryValid, bindQueryId} = slotTab[{bindQueryProg, bindQuerySpace}];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upId       <= '0;
      upPtr      <= '0;
      memWrEn    <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
      errFlag    <= 1'b0;
      flushPulse <= 1'b0;
    end else begin
      memWrEn    <= 1'b0;
      flushPulse <= strobe.flush;
      if (strobe.defBad || strobe.bindBad || (strobe.dataWr && !inRange))
        errFlag <= 1'b1;
      if (strobe.selUp) begin
        upId  <= regData[ID_W-1:0];
        upPtr <= PTR_W'(regData[8 +: OFS_W]);
      end else if (strobe.dataWr && inRange) begin
        memWrEn   <= 1'b1;
        memWrAddr <= defBase[upId] + ADDR_W'({upPtr[OFS_W-1:0], 2'b00});
        memWrData <= regData;
        upPtr     <= upPtr + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/cbu_upload_engine.sv
module cbu_upload_engine
  import cbu_pkg::*;
#(
  parameter int NUM_BUF   = 128,
  parameter int NUM_SPACE = 16,
  parameter int NUM_PROG  = 16,
  parameter int ADDR_W    = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [SEL_W-1:0]             regSel,
  input  logic [31:0]                  regData,
  input  logic [$clog2(NUM_PROG)-1:0]  bindQueryProg,
  input  logic [$clog2(NUM_SPACE)-1:0] bindQuerySpace,
  output logic                         memWrEn,
  output logic [ADDR_W-1:0]            memWrAddr,
  output logic [31:0]                  memWrData,
  output logic                         errFlag,
  output logic                         flushPulse,
  output logic [$clog2(NUM_BUF)-1:0]   bindQueryId,
  output logic                         bindQueryValid
);
  cbu_strobe_t strobe;

  cbu_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .regData (regData),
    .strobe  (strobe)
  );

  cbu_datapath #(
    .NUM_BUF   (NUM_BUF),
    .NUM_SPACE (NUM_SPACE),
    .NUM_PROG  (NUM_PROG),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .regData        (regData),
    .bindQueryProg  (bindQueryProg),
    .bindQuerySpace (bindQuerySpace),
    .memWrEn        (memWrEn),
    .memWrAddr      (memWrAddr),
    .memWrData      (memWrData),
    .errFlag        (errFlag),
    .flushPulse     (flushPulse),
    .bindQueryId    (bindQueryId),
    .bindQueryValid (bindQueryValid)
  );
endmodule

// File: rtl/cbu_upload_engine_sva.sv
module cbu_upload_engine_sva (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [4:0]  regSel,
  input logic [31:0] regData,
  input logic        memWrEn,
  input logic [31:0] memWrData,
  input logic        errFlag,
  input logic        flushPulse
);
  // R1: clean outputs on the first edge out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!memWrEn && !errFlag && !flushPulse));

  // R4: a memory write only follows a data-register write
  assert_write_from_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(regWrEn && regSel[4]));

  // R4: the written word is the data register value
  assert_write_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData == $past(regData)));

  // R7: misaligned size raises the error
  assert_bad_size_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 5'd2 && regData[7:0] != 8'd0) |=> errFlag);

  // R9: bind without the required bit raises the error
  assert_bad_bind_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 5'd4 && !regData[0]) |=> errFlag);

  // R10: a flush pulse only follows a zero written to the flush select
  assert_flush_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(regWrEn && regSel == 5'd5 && regData == 32'd0));

  // R11: the error flag never clears on its own
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind cbu_upload_engine cbu_upload_engine_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regData    (regData),
  .memWrEn    (memWrEn),
  .memWrData  (memWrData),
  .errFlag    (errFlag),
  .flushPulse (flushPulse)
);

// File: tb/cbu_upload_engine_test.sv
module cbu_upload_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regSel = '0;
  logic [31:0] regData = '0;
  logic [3:0]  bindQueryProg = '0;
  logic [3:0]  bindQuerySpace = '0;
  logic        memWrEn;
  logic [39:0] memWrAddr;
  logic [31:0] memWrData;
  logic        errFlag;
  logic        flushPulse;
  logic [6:0]  bindQueryId;
  logic        bindQueryValid;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbu_upload_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regData(regData),
    .bindQueryProg(bindQueryProg), .bindQuerySpace(bindQuerySpace),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .errFlag(errFlag), .flushPulse(flushPulse),
    .bindQueryId(bindQueryId), .bindQueryValid(bindQueryValid)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    regWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(logic [4:0] sel, logic [31:0] data);
    regWrEn = 1'b1;
    regSel  = sel;
    regData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    regData = '0;
  endtask

  task automatic defineBuf(logic [6:0] id, logic [39:0] base, logic [15:0] size);
    writeReg(5'd0, {24'd0, base[39:32]});
    writeReg(5'd1, base[31:0]);
    writeReg(5'd2, {9'd0, id, size});
  endtask

  task automatic selectUp(logic [6:0] id, logic [13:0] ofs);
    writeReg(5'd3, {10'd0, ofs, 1'b0, id});
  endtask

  task automatic expectWrite(string req, logic [39:0] addr, logic [31:0] word);
    check(req, "memWrEn", 64'(memWrEn), 64'd1);
    check(req, "memWrAddr", 64'(memWrAddr), 64'(addr));
    check(req, "memWrData", 64'(memWrData), 64'(word));
  endtask

  task automatic query(logic [3:0] prog, logic [3:0] space);
    bindQueryProg = prog;
    bindQuerySpace = space;
    #1;
  endtask

  task automatic testReset();
    check("R1", "memWrEn", 64'(memWrEn), 64'd0);
    check("R1", "errFlag", 64'(errFlag), 64'd0);
    check("R1", "flushPulse", 64'(flushPulse), 64'd0);
    query(4'd3, 4'd7);
    check("R1", "bindQueryValid", 64'(bindQueryValid), 64'd0);
  endtask

  task automatic testUpload();
    doReset();
    defineBuf(7'd5, 40'h12_0000_1000, 16'h0200);
    selectUp(7'd5, 14'd0);
    writeReg(5'd16, 32'hDEAD_0001);
    expectWrite("R2", 40'h12_0000_1000, 32'hDEAD_0001);
    writeReg(5'd31, 32'hDEAD_0002);
    expectWrite("R4", 40'h12_0000_1004, 32'hDEAD_0002);
    @(negedge clk);
    check("R4", "memWrEn one cycle", 64'(memWrEn), 64'd0);
    selectUp(7'd5, 14'd127);
    check("R3", "select gives no write", 64'(memWrEn), 64'd0);
    writeReg(5'd23, 32'h0000_5A5A);
    expectWrite("R3", 40'h12_0000_11FC, 32'h0000_5A5A);
    check("R6", "no error in range", 64'(errFlag), 64'd0);
    writeReg(5'd17, 32'h1111_2222);
    check("R6", "oob dropped", 64'(memWrEn), 64'd0);
    check("R6", "oob error", 64'(errFlag), 64'd1);
    defineBuf(7'd5, 40'h12_0000_1000, 16'h0300);
    writeReg(5'd18, 32'h3333_4444);
    expectWrite("R6", 40'h12_0000_1200, 32'h3333_4444);
    repeat (3) @(negedge clk);
    check("R11", "errFlag sticky", 64'(errFlag), 64'd1);
  endtask

  task automatic testFullSize();
    doReset();
    defineBuf(7'd127, 40'h00_8000_0000, 16'h0000);
    selectUp(7'd127, 14'h3FFF);
    writeReg(5'd20, 32'hCAFE_F00D);
    expectWrite("R5", 40'h00_8000_FFFC, 32'hCAFE_F00D);
    check("R5", "last word no error", 64'(errFlag), 64'd0);
    writeReg(5'd20, 32'hCAFE_F00E);
    check("R5", "past 64KiB dropped", 64'(memWrEn), 64'd0);
    check("R5", "past 64KiB error", 64'(errFlag), 64'd1);
  endtask

  task automatic testBadSize();
    doReset();
    defineBuf(7'd9, 40'h01_0000_4000, 16'h0100);
    check("R7", "good define no error", 64'(errFlag), 64'd0);
    defineBuf(7'd9, 40'h02_0000_8000, 16'h0180);
    check("R7", "bad define error", 64'(errFlag), 64'd1);
    selectUp(7'd9, 14'd0);
    writeReg(5'd16, 32'h0BAD_0001);
    expectWrite("R7", 40'h01_0000_4000, 32'h0BAD_0001);
    selectUp(7'd9, 14'd64);
    writeReg(5'd16, 32'h0BAD_0002);
    check("R7", "old size kept", 64'(memWrEn), 64'd0);
  endtask

  task automatic testUndefined();
    doReset();
    selectUp(7'd3, 14'd0);
    writeReg(5'd16, 32'h1234_5678);
    check("R6", "undefined dropped", 64'(memWrEn), 64'd0);
    check("R6", "undefined error", 64'(errFlag), 64'd1);
  endtask

  task automatic testBind();
    doReset();
    writeReg(5'd4, (32'h45 << 12) | (32'd7 << 8) | (32'd3 << 4) | 32'd1);
    check("R8", "good bind no error", 64'(errFlag), 64'd0);
    query(4'd3, 4'd7);
    check("R8", "bound valid", 64'(bindQueryValid), 64'd1);
    check("R8", "bound id", 64'(bindQueryId), 64'h45);
    query(4'd3, 4'd6);
    check("R8", "other space unbound", 64'(bindQueryValid), 64'd0);
    query(4'd2, 4'd7);
    check("R8", "other type unbound", 64'(bindQueryValid), 64'd0);
    writeReg(5'd4, (32'h11 << 12) | (32'd7 << 8) | (32'd3 << 4));
    check("R9", "bad bind error", 64'(errFlag), 64'd1);
    query(4'd3, 4'd7);
    check("R9", "table unchanged", 64'(bindQueryId), 64'h45);
  endtask

  task automatic testFlush();
    doReset();
    writeReg(5'd5, 32'd0);
    check("R10", "flush pulse", 64'(flushPulse), 64'd1);
    @(negedge clk);
    check("R10", "pulse one cycle", 64'(flushPulse), 64'd0);
    writeReg(5'd5, 32'd5);
    check("R10", "nonzero no pulse", 64'(flushPulse), 64'd0);
    check("R10", "nonzero no error", 64'(errFlag), 64'd0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUpload();
    testFullSize();
    testBadSize();
    testUndefined();
    testBind();
    testFlush();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule